// File: doc/BRIEF.md
# Local Interrupt Selection Arbiter

This block decides which local interrupt a processor core should take next, or that it should take none. Each interrupt source has a pending bit and an enable bit. A per-source routing mask sends every source either to the machine handler group or to the supervisor handler group. Each group is then gated by a global enable whose meaning depends on the privilege level the core is running at. Among the sources that survive the gating, the lowest-numbered source wins.

The result is a take flag and a cause number, meant to feed the trap-entry logic of the core. By default both outputs pass through one register stage, which keeps the selection logic off the core's critical path. Setting the `REG_OUT` parameter to 0 makes the block purely combinational.

Top module: `irq_pick_arbiter`

## Requirements
- R1: A source can win only when both its pending bit and its enable bit are 1; a pending source whose enable bit is 0 never wins.
- R2: A source whose routing bit is 0 (machine group) is eligible when the privilege level is below machine, or when it is machine and `m_gie` is 1.
- R3: A source whose routing bit is 1 (supervisor group) is eligible when the privilege level is user, or when it is supervisor and `s_gie` is 1; at machine level it is never eligible.
- R4: The routing bit of each source alone picks which of the two group enables gates that source, so sources from both groups can compete in the same cycle.
- R5: When any source is eligible, `take` is 1 and `cause` is the index of the lowest-numbered eligible source (bit 0 has the highest priority).
- R6: When no source is eligible, `take` is 0 and `cause` is 0.
- R7: The privilege input is encoded user = 0, supervisor = 1, machine = 3; the code 2 behaves exactly like user.
- R8: With `REG_OUT` = 1 (the default), `take` and `cause` show the selection for the inputs present at the previous rising clock edge, and a synchronous active-high `rst` forces `take` = 0 and `cause` = 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| irq_pend | input | 16 | Pending bit per interrupt source |
| irq_en | input | 16 | Enable bit per interrupt source |
| irq_route | input | 16 | Per-source routing: 1 = supervisor group, 0 = machine group |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 2 treated as user, 3 machine |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| take | output | 1 | An interrupt should be taken |
| cause | output | 4 | Index of the winning source, 0 when `take` is 0 |

## Verification
With the default registered output, every result is due exactly one rising edge after its inputs are applied, so the bench drives inputs on the falling edge and compares the outputs on the following falling edge against the reference value it computed for the inputs it drove one cycle earlier. Reset clearing is checked at the first falling edge after a reset edge while inputs that would otherwise fire are held. Directed cases cover each privilege level against both groups and both enables, then a long run of random vectors is compared on every clock.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } priv_lvl_e;

  // The unused code folds onto the user level.
  function automatic priv_lvl_e fold_level(input logic [1:0] code);
    priv_lvl_e lvl;
    case (code)
      2'd1:    lvl = LVL_SUPER;
      2'd3:    lvl = LVL_MACH;
      default: lvl = LVL_USER;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/irq_group_gate.sv
module irq_group_gate
  import irq_pick_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] route,
  input  logic [1:0]         priv,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic [NUM_IRQ-1:0] eligible
);

  priv_lvl_e lvl;
  logic      mach_open;
  logic      sup_open;
  logic [NUM_IRQ-1:0] cand;

  always_comb begin
    lvl       = fold_level(priv);
    mach_open = (lvl != LVL_MACH) || m_gie;
    sup_open  = (lvl == LVL_USER) || ((lvl == LVL_SUPER) && s_gie);
    cand      = pend & en;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    assign eligible[g] = cand[g] & (route[g] ? sup_open : mach_open);
  end

endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int NUM_IRQ = 16,
  localparam int CAUSE_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] vec,
  output logic               hit,
  output logic [CAUSE_W-1:0] idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = CAUSE_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int  CAUSE_W = 4,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_d,
  input  logic [CAUSE_W-1:0] cause_d,
  output logic               take_q,
  output logic [CAUSE_W-1:0] cause_q
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        take_q  <= 1'b0;
        cause_q <= '0;
      end else begin
        take_q  <= take_d;
        cause_q <= cause_d;
      end
    end
  end else begin : g_comb
    assign take_q  = take_d;
    assign cause_q = cause_d;
  end

endmodule

// File: rtl/irq_pick_arbiter.sv
module irq_pick_arbiter
  import irq_pick_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int CAUSE_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_route,
  input  logic [1:0]         priv,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic               take,
  output logic [CAUSE_W-1:0] cause
);

  logic [NUM_IRQ-1:0] eligible;
  logic               take_c;
  logic [CAUSE_W-1:0] cause_c;

  irq_group_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .pend     (irq_pend),
    .en       (irq_en),
    .route    (irq_route),
    .priv     (priv),
    .m_gie    (m_gie),
    .s_gie    (s_gie),
    .eligible (eligible)
  );

  irq_lsb_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .vec (eligible),
    .hit (take_c),
    .idx (cause_c)
  );

  irq_out_stage #(.CAUSE_W(CAUSE_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .take_d  (take_c),
    .cause_d (cause_c),
    .take_q  (take),
    .cause_q (cause)
  );

  // R1: a winner is always pending and enabled
  a_r1_winner_armed: assert property (@(posedge clk) disable iff (rst)
    take_c |-> (irq_pend[cause_c] && irq_en[cause_c]));

  // R3: at machine level a supervisor-routed source never wins
  a_r3_mach_no_sup: assert property (@(posedge clk) disable iff (rst)
    (take_c && priv == 2'd3) |-> !irq_route[cause_c]);

  // R2: machine level with machine enable off takes nothing
  a_r2_mach_masked: assert property (@(posedge clk) disable iff (rst)
    (priv == 2'd3 && !m_gie) |-> !take_c);

  // R5: no eligible source below the winner
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    take_c |-> ((eligible & ((NUM_IRQ'(1) << cause_c) - NUM_IRQ'(1))) == '0));

  // R6: no winner means nothing eligible and cause zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !take_c |-> (eligible == '0 && cause_c == '0));

  if (REG_OUT) begin : g_chk_reg
    // R8: reset clears the registered outputs
    a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (!take && cause == '0));
    // R8: outputs follow the selection one edge later
    a_r8_one_stage: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (take == $past(take_c) && cause == $past(cause_c)));
  end

endmodule

// File: tb/irq_pick_arbiter_tb_top.sv
module irq_pick_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_pend = '0;
  logic [15:0] irq_en = '0;
  logic [15:0] irq_route = '0;
  logic [1:0]  priv = '0;
  logic        m_gie = 1'b0;
  logic        s_gie = 1'b0;
  logic        take;
  logic [3:0]  cause;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit         exp_take;
  logic [3:0] exp_cause;
  string      exp_tag;

  always #5 clk = ~clk;

  irq_pick_arbiter dut_i (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_route(irq_route), .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
    .take(take), .cause(cause)
  );

  // Behavioural reference straight from the requirements.
  task automatic ref_model(input logic [15:0] p, e, d, input logic [1:0] pr,
                           input logic mi, si, output bit t, output logic [3:0] c);
    int lvl;
    bit men, sen;
    lvl = (pr == 2'd3) ? 3 : (pr == 2'd1) ? 1 : 0;
    men = (lvl < 3) || mi;
    sen = (lvl < 1) || (lvl == 1 && si);
    t = 1'b0;
    c = 4'd0;
    for (int i = 0; i < 16; i++) begin
      if (!t && p[i] && e[i] && (d[i] ? sen : men)) begin
        t = 1'b1;
        c = 4'(i);
      end
    end
  endtask

  task automatic check_out(input bit t, input logic [3:0] c, input string tag);
    n_chk++;
    if (take !== t || cause !== c) begin
      n_fail++;
      $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
               tag, take, cause, t, c);
    end
  endtask

  // On a falling edge: check the result of the previous drive, then drive new inputs.
  task automatic step(input logic [15:0] p, e, d, input logic [1:0] pr,
                      input logic mi, si, input string tag);
    @(negedge clk);
    check_out(exp_take, exp_cause, exp_tag);
    irq_pend = p; irq_en = e; irq_route = d; priv = pr; m_gie = mi; s_gie = si;
    ref_model(p, e, d, pr, mi, si, exp_take, exp_cause);
    exp_tag = tag;
  endtask

  initial begin
    // R8: reset holds outputs cleared although inputs would fire
    irq_pend = 16'h0001; irq_en = 16'h0001; priv = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_out(1'b0, 4'd0, "R8 reset");
    rst = 1'b0;
    ref_model(irq_pend, irq_en, irq_route, priv, m_gie, s_gie, exp_take, exp_cause);
    exp_tag = "R8 first cycle after reset";

    step(16'h0010, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1, "R1 enable off");
    step(16'h0010, 16'h0030, 16'h0000, 2'd0, 1'b1, 1'b1, "R1 enabled");
    step(16'h0004, 16'h0004, 16'h0000, 2'd3, 1'b0, 1'b1, "R2 mach gie off");
    step(16'h0004, 16'h0004, 16'h0000, 2'd3, 1'b1, 1'b0, "R2 mach gie on");
    step(16'h0004, 16'h0004, 16'h0000, 2'd1, 1'b0, 1'b0, "R2 below mach");
    step(16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b1, 1'b0, "R3 super gie off");
    step(16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b0, 1'b1, "R3 super gie on");
    step(16'h0020, 16'h0020, 16'h0020, 2'd0, 1'b0, 1'b0, "R3 user level");
    step(16'h0020, 16'h0020, 16'h0020, 2'd3, 1'b1, 1'b1, "R3 mach blocks super");
    step(16'h0088, 16'h0088, 16'h0008, 2'd1, 1'b0, 1'b0, "R4 mixed groups");
    step(16'h0088, 16'h0088, 16'h0080, 2'd3, 1'b1, 1'b1, "R4 mixed at mach");
    step(16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R5 all set");
    step(16'h8000, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R5 top bit");
    step(16'hA400, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R5 middle bit");
    step(16'h0000, 16'hFFFF, 16'hFFFF, 2'd0, 1'b1, 1'b1, "R6 nothing pending");
    step(16'h0040, 16'h0040, 16'h0040, 2'd2, 1'b0, 1'b0, "R7 code two super");
    step(16'h0040, 16'h0040, 16'h0000, 2'd2, 1'b0, 1'b0, "R7 code two mach");
    for (int k = 0; k < 3000; k++) begin
      step(16'($urandom), 16'($urandom), 16'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom), "R5 random");
    end
    @(negedge clk);
    check_out(exp_take, exp_cause, exp_tag);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule